// File: doc/BRIEF.md
# Load/Store Byte Alignment Unit

This block sits between a 32-bit processor core and a data memory that is addressed by word. It adapts sub-word accesses to that memory. It has no clock and no state, so every output follows its inputs within the same cycle.

On a store, the unit copies the low byte or low halfword of the store operand into every lane of the write word. It also produces a byte-enable mask from the two low address bits, and the memory writes only the lanes the mask selects. On a load, it takes the addressed byte or halfword out of the memory read word. It then zero-extends or sign-extends that value to 32 bits, depending on an unsigned flag.

The core still drives its own write strobe to the memory. The mask only matters while that strobe is active. Misaligned halfword and word addresses are not trapped here: the unit ignores the address bits that do not apply to the access size.

Top module: `lsu_byte_align`

## Requirements
- R1: The access size is encoded as 2'b00 byte, 2'b01 halfword and 2'b10 word. The code 2'b11 behaves exactly like word.
- R2: For a byte access, address bits [1:0] = 0, 1, 2 or 3 give byte enables 4'b0001, 4'b0010, 4'b0100 or 4'b1000 respectively.
- R3: For a halfword access, byte enables are 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Address bit 0 has no effect.
- R4: For a word access, byte enables are 4'b1111 whatever the address bits are.
- R5: The write data holds store-data bits [7:0] in all four byte lanes for a byte access, and bits [15:0] in both halves for a halfword access. For a word access it is the store data unchanged.
- R6: A byte load returns read-word bits [8*a+7:8*a], where a is address bits [1:0]. The result is zero-extended when the unsigned flag is 1 and sign-extended from its bit 7 when the flag is 0.
- R7: A halfword load returns the lower half of the read word when address bit 1 is 0 and the upper half when it is 1. Address bit 0 has no effect. The result is zero-extended when the unsigned flag is 1 and sign-extended from bit 15 when it is 0.
- R8: A word load returns the read word unchanged. Neither the unsigned flag nor the address bits have an effect.
- R9: All three outputs are purely combinational functions of the present inputs, so a new input is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_size | input | 2 | Access size code (see R1) |
| unsigned_ld | input | 1 | 1 selects zero extension on loads |
| addr_lo | input | 2 | Low two bits of the computed address |
| st_data | input | 32 | Store operand from the core |
| rd_word | input | 32 | Word read from data memory |
| wr_data | output | 32 | Lane-duplicated write word to memory |
| wr_be | output | 4 | Byte-enable mask for the write |
| ld_result | output | 32 | Extracted, extended load value |

## Verification
The bench applies every combination of size code, address offset and unsigned flag to data patterns in which bit 7 and bit 15 take both values. This catches a design that extends from the wrong bit, or that treats the unsigned flag backwards. Unaligned halfword and word offsets are included, which exposes a design that lets address bit 0 move a halfword lane or lets any address bit move the word mask. The reserved size code 2'b11 is driven to show that it does not fall into the byte or halfword path. Lane patterns with a different value in each byte show whether a wrong lane was selected on a load, or whether a lane was left empty on store duplication.

// File: rtl/lsu_align_pkg.sv
// Package: shared size encoding and width constants for the alignment unit.
// Assumes a 32-bit data path split into 8-bit lanes.
package lsu_align_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lsu_store_dup.sv
// Module: lsu_store_dup
// Copies the low byte or low halfword of the store operand into every lane
// of the write word. Word and reserved sizes pass the operand through.
// Assumes DATA_W is a multiple of 16.
module lsu_store_dup
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int N_BYTES = DATA_W / LANE_W;
    localparam int N_HALVES = DATA_W / (2 * LANE_W);

    // Pick the duplicated pattern for the requested size.
    always_comb begin
        unique case (acc_size_e'(size_i))
            SZ_BYTE: data_o = {N_BYTES{data_i[LANE_W-1:0]}};
            SZ_HALF: data_o = {N_HALVES{data_i[2*LANE_W-1:0]}};
            default: data_o = data_i;
        endcase
    end

    // Each lane must carry the store byte (R5).
    always_comb begin
        if (size_i == SZ_BYTE) begin
            for (int k = 0; k < N_BYTES; k++) begin
                p_byte_lanes_r5: assert (data_o[k*LANE_W +: LANE_W] == data_i[LANE_W-1:0])
                    else $error("byte lane %0d not duplicated", k);
            end
        end
    end
endmodule

// File: rtl/lsu_be_gen.sv
// Module: lsu_be_gen
// Builds the per-lane write mask from the access size and the address
// offset. Offset bits below the access granularity are ignored.
// Assumes at least four lanes (OFS_W >= 2).
module lsu_be_gen
    import lsu_align_pkg::*;
#(
    parameter int N_LANES = 4,
    localparam int OFS_W = $clog2(N_LANES)
) (
    input  logic [1:0]         size_i,
    input  logic [OFS_W-1:0]   ofs_i,
    output logic [N_LANES-1:0] be_o
);
    logic is_byte;
    logic is_half;

    // Decode the size code into the two sub-word cases.
    always_comb begin
        is_byte = (size_i == SZ_BYTE);
        is_half = (size_i == SZ_HALF);
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(g);
        // One lane's enable: exact match, same half, or whole word.
        always_comb begin
            if (is_byte)
                be_o[g] = (ofs_i == LANE_IDX);
            else if (is_half)
                be_o[g] = (ofs_i[OFS_W-1:1] == LANE_IDX[OFS_W-1:1]);
            else
                be_o[g] = 1'b1;
        end
    end

    // Enable counts must match the access size (R2, R3, R4).
    always_comb begin
        if (is_byte) begin
            p_be_single_r2: assert ($countones(be_o) == 1)
                else $error("byte mask not one-hot");
        end else if (is_half) begin
            p_be_pair_r3: assert ($countones(be_o) == 2)
                else $error("half mask not two lanes");
        end else begin
            p_be_full_r4: assert ($countones(be_o) == N_LANES)
                else $error("word mask not full");
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Module: lsu_load_extract
// Selects the addressed byte or halfword of the read word and extends it
// with zeros or with its sign bit. Word loads pass the read word through.
// Assumes at least four 8-bit lanes.
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int N_LANES = DATA_W / LANE_W,
    localparam int OFS_W = $clog2(N_LANES)
) (
    input  logic [1:0]        size_i,
    input  logic              unsigned_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] rd_i,
    output logic [DATA_W-1:0] ld_o
);
    logic [LANE_W-1:0]   sel_byte;
    logic [2*LANE_W-1:0] sel_half;

    // Pull out the addressed byte and the addressed halfword.
    always_comb begin
        sel_byte = rd_i[{ofs_i, 3'b000} +: LANE_W];
        sel_half = rd_i[{ofs_i[OFS_W-1:1], 4'b0000} +: 2*LANE_W];
    end

    // Extend the selected piece to the full width.
    always_comb begin
        unique case (acc_size_e'(size_i))
            SZ_BYTE: ld_o = {{(DATA_W-LANE_W){sel_byte[LANE_W-1] & ~unsigned_i}}, sel_byte};
            SZ_HALF: ld_o = {{(DATA_W-2*LANE_W){sel_half[2*LANE_W-1] & ~unsigned_i}}, sel_half};
            default: ld_o = rd_i;
        endcase
    end

    // Upper bits of sub-word loads must all copy one value (R6, R7).
    always_comb begin
        if (size_i == SZ_BYTE) begin
            p_byte_ext_r6: assert (ld_o[DATA_W-1:LANE_W] == '0 || ld_o[DATA_W-1:LANE_W-1] == '1)
                else $error("byte extension broken");
        end
        if (size_i == SZ_HALF && unsigned_i) begin
            p_half_zext_r7: assert (ld_o[DATA_W-1:2*LANE_W] == '0)
                else $error("half zero extension broken");
        end
    end
endmodule

// File: rtl/lsu_byte_align.sv
// Module: lsu_byte_align (top)
// Adapts sub-word loads and stores to a word-addressed data memory. It is
// purely combinational, and the write strobe stays with the core.
// Assumes 32-bit data; offsets not matching the size are ignored.
module lsu_byte_align
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int N_LANES = DATA_W / LANE_W,
    localparam int OFS_W = $clog2(N_LANES)
) (
    input  logic [1:0]         acc_size,
    input  logic               unsigned_ld,
    input  logic [OFS_W-1:0]   addr_lo,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [DATA_W-1:0]  rd_word,
    output logic [DATA_W-1:0]  wr_data,
    output logic [N_LANES-1:0] wr_be,
    output logic [DATA_W-1:0]  ld_result
);
    lsu_store_dup #(.DATA_W(DATA_W)) u_dup (
        .size_i (acc_size),
        .data_i (st_data),
        .data_o (wr_data)
    );

    lsu_be_gen #(.N_LANES(N_LANES)) u_be (
        .size_i (acc_size),
        .ofs_i  (addr_lo),
        .be_o   (wr_be)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
        .size_i     (acc_size),
        .unsigned_i (unsigned_ld),
        .ofs_i      (addr_lo),
        .rd_i       (rd_word),
        .ld_o       (ld_result)
    );

    // Word-class loads never alter the read word (R1, R8).
    always_comb begin
        if (acc_size[1]) begin
            p_word_pass_r8: assert (ld_result == rd_word)
                else $error("word load altered data");
        end
    end
endmodule

// File: tb/lsu_byte_align_test.sv
module lsu_byte_align_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        unsigned_ld = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic [31:0] st_data = '0;
    logic [31:0] rd_word = '0;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [31:0] ld_result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    lsu_byte_align uut (
        .acc_size    (acc_size),
        .unsigned_ld (unsigned_ld),
        .addr_lo     (addr_lo),
        .st_data     (st_data),
        .rd_word     (rd_word),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .ld_result   (ld_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Behavioural reference: byte count derived from size, shifts for lanes.
    function automatic int nbytes(input logic [1:0] sz);
        if (sz == 2'b00) return 1;
        if (sz == 2'b01) return 2;
        return 4;
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] a);
        int n = nbytes(sz);
        int base = (int'(a) / n) * n;
        logic [3:0] m = '0;
        for (int i = base; i < base + n; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] ref_wd(input logic [1:0] sz, input logic [31:0] d);
        int n = nbytes(sz);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(i % n) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ref_ld(input logic [1:0] sz, input logic u,
                                           input logic [1:0] a, input logic [31:0] w);
        int n = nbytes(sz);
        int base = (int'(a) / n) * n;
        logic [31:0] v = w >> (8 * base);
        if (n == 4) return w;
        for (int b = 8 * n; b < 32; b++) v[b] = u ? 1'b0 : v[8*n - 1];
        return v;
    endfunction

    task automatic check_now(input string tag);
        logic [3:0]  e_be = ref_be(acc_size, addr_lo);
        logic [31:0] e_wd = ref_wd(acc_size, st_data);
        logic [31:0] e_ld = ref_ld(acc_size, unsigned_ld, addr_lo, rd_word);
        string ltag = (acc_size == 2'b00) ? "R6" : (acc_size == 2'b01) ? "R7" : "R8";
        string btag = (acc_size == 2'b00) ? "R2" : (acc_size == 2'b01) ? "R3" : "R4";
        checks = checks + 3;
        if (wr_be !== e_be) begin
            failures++;
            $display("FAIL %s/%s be sz=%b a=%0d actual=%b expected=%b", btag, tag, acc_size, addr_lo, wr_be, e_be);
        end
        if (wr_data !== e_wd) begin
            failures++;
            $display("FAIL R5/%s wdata sz=%b actual=%h expected=%h", tag, acc_size, wr_data, e_wd);
        end
        if (ld_result !== e_ld) begin
            failures++;
            $display("FAIL %s/%s load sz=%b u=%b a=%0d actual=%h expected=%h", ltag, tag, acc_size, unsigned_ld, addr_lo, ld_result, e_ld);
        end
    endtask

    // Drive just after a rising edge, compare on the falling edge.
    task automatic apply(input logic [1:0] sz, input logic u, input logic [1:0] a,
                         input logic [31:0] sd, input logic [31:0] rw, input string tag);
        @(posedge clk);
        #1;
        acc_size = sz; unsigned_ld = u; addr_lo = a; st_data = sd; rd_word = rw;
        @(negedge clk);
        check_now(tag);
    endtask

    logic [31:0] pats [4] = '{32'h80FF_7F01, 32'h7F80_01FE, 32'hA5C3_3C5A, 32'h0123_8967};

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_now("R9 reset");
        rst_n = 1'b1;
        // Exhaustive control sweep over several data patterns (R1..R8).
        foreach (pats[p]) begin
            for (int sz = 0; sz < 4; sz++)
                for (int u = 0; u < 2; u++)
                    for (int a = 0; a < 4; a++)
                        apply(2'(sz), 1'(u), 2'(a), ~pats[p], pats[p], sz == 3 ? "R1" : "sweep");
        end
        // Same-cycle response to back-to-back changes (R9).
        for (int i = 0; i < 200; i++)
            apply(2'($urandom), 1'($urandom), 2'($urandom), $urandom, $urandom, "R9");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule